// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides, once per clock, whether an interrupt controller should signal a new interrupt to its processor and which request line that interrupt belongs to. It receives the pending-request vector, the mask vector and the in-service vector, together with a rotating base pointer. The base pointer sets the line that currently holds the highest priority. Priority then falls off in circular order from that line.

A pending, unmasked request is granted only when it strictly outranks every line that is already in service. Interrupts are therefore nested by priority. When the block acts as the master of a cascade and the nested-cascade option is on, the in-service bit of the cascade input is left out of the current service level. This lets a second, higher request from the slave controller reach the processor while an earlier slave interrupt is still being serviced.

A separate probe port runs the same circular search over any vector that the surrounding logic supplies. End-of-interrupt handling uses it to find the highest-priority in-service line. All results are registered and appear one cycle after the inputs are sampled.

Top module: `rot_prio_resolver`

## Requirements
- R1: While reset is high, the next clock edge sets the outputs to these values: irq_o=0, line_o=0, probe_prio_o=NLINES (8) and probe_line_o=0.
- R2: A request is a candidate only when its req_i bit is 1 and its mask_i bit is 0. A masked line is never granted.
- R3: Priority index p stands for line (p + base_i) mod NLINES, and a smaller p means a higher priority. The granted line is the candidate with the smallest index. With base_i=0, line 0 ranks highest and line 7 lowest.
- R4: The service level is the smallest priority index that has a set in-service bit, or NLINES when no bit is set. A grant requires the winning candidate's index to be strictly less than the service level. A candidate at the same index or at a larger index is not granted.
- R5: When no candidate exists, or when the best candidate loses to the service level, irq_o=0 and line_o=0.
- R6: When nested_i=1, the in-service bit at line CASCADE_LINE (2) is ignored in the service level. All other in-service bits still count. When nested_i=0, every in-service bit counts.
- R7: probe_prio_o is the priority index of the highest-priority set bit of probe_i, or NLINES (8) when probe_i is zero. probe_line_o is (probe_prio_o + base_i) mod NLINES, or 0 when probe_i is zero.
- R8: Each output reflects the inputs sampled at the previous rising clock edge. An input change between edges does not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NLINES | Pending requests |
| mask_i | input | NLINES | Mask bits, 1 = blocked |
| insvc_i | input | NLINES | In-service bits |
| base_i | input | $clog2(NLINES) | Line holding the highest priority |
| nested_i | input | 1 | Ignore the cascade input's in-service bit |
| probe_i | input | NLINES | Vector for the helper search |
| irq_o | output | 1 | New interrupt should be raised |
| line_o | output | $clog2(NLINES) | Granted line number |
| probe_prio_o | output | $clog2(NLINES)+1 | Priority index of probe_i, NLINES if none |
| probe_line_o | output | $clog2(NLINES) | Line number of the probe result |

## Verification
The bench builds the block with its default parameters: eight lines, the cascade input on line 2, and a three-bit base pointer. With these values the wrap of the circular search can be reached from every one of the eight base positions. The bench drives the cascade exception with the cascade bit alone and with a second in-service bit beside it. A long sweep of random request, mask, in-service and probe vectors covers every base value and compares the outputs against a reference search written from the requirements.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  localparam int DEF_NLINES  = 8;
  localparam int DEF_CASCADE = 2;
endpackage

// File: rtl/rpr_search.sv
module rpr_search #(
  parameter int N = rpr_pkg::DEF_NLINES,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] base_i,
  output logic [W:0]   prio_o
);
  always_comb begin
    logic [W-1:0] idx;
    prio_o = (W+1)'(N);
    for (int p = N - 1; p >= 0; p--) begin
      idx = W'(p) + base_i;
      if (vec_i[idx]) prio_o = (W+1)'(p);
    end
  end
endmodule

// File: rtl/rpr_nest_filter.sv
module rpr_nest_filter #(
  parameter int N    = rpr_pkg::DEF_NLINES,
  parameter int CASC = rpr_pkg::DEF_CASCADE
) (
  input  logic [N-1:0] vec_i,
  input  logic         nested_i,
  output logic [N-1:0] vec_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == CASC) begin : g_casc
      assign vec_o[g] = vec_i[g] & ~nested_i;
    end else begin : g_plain
      assign vec_o[g] = vec_i[g];
    end
  end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int NLINES       = rpr_pkg::DEF_NLINES,
  parameter int CASCADE_LINE = rpr_pkg::DEF_CASCADE,
  localparam int W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_i,
  input  logic [NLINES-1:0] mask_i,
  input  logic [NLINES-1:0] insvc_i,
  input  logic [W-1:0]      base_i,
  input  logic              nested_i,
  input  logic [NLINES-1:0] probe_i,
  output logic              irq_o,
  output logic [W-1:0]      line_o,
  output logic [W:0]        probe_prio_o,
  output logic [W-1:0]      probe_line_o
);
  localparam logic [W:0] NONE = (W+1)'(NLINES);

  logic [NLINES-1:0] cand;
  logic [NLINES-1:0] isr_eff;
  logic [W:0]        req_prio;
  logic [W:0]        svc_prio;
  logic [W:0]        prb_prio;
  logic              grant;

  assign cand = req_i & ~mask_i;

  rpr_nest_filter #(.N(NLINES), .CASC(CASCADE_LINE)) u_filter (
    .vec_i(insvc_i), .nested_i(nested_i), .vec_o(isr_eff)
  );

  rpr_search #(.N(NLINES)) u_req_search (
    .vec_i(cand), .base_i(base_i), .prio_o(req_prio)
  );

  rpr_search #(.N(NLINES)) u_svc_search (
    .vec_i(isr_eff), .base_i(base_i), .prio_o(svc_prio)
  );

  rpr_search #(.N(NLINES)) u_probe_search (
    .vec_i(probe_i), .base_i(base_i), .prio_o(prb_prio)
  );

  assign grant = req_prio < svc_prio;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o        <= 1'b0;
      line_o       <= '0;
      probe_prio_o <= NONE;
      probe_line_o <= '0;
    end else begin
      irq_o        <= grant;
      line_o       <= grant ? req_prio[W-1:0] + base_i : '0;
      probe_prio_o <= prb_prio;
      probe_line_o <= (prb_prio == NONE) ? '0 : prb_prio[W-1:0] + base_i;
    end
  end
endmodule

// File: rtl/rot_prio_resolver_checker.sv
module rot_prio_resolver_checker #(
  parameter int NLINES       = rpr_pkg::DEF_NLINES,
  parameter int CASCADE_LINE = rpr_pkg::DEF_CASCADE,
  localparam int W = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst,
  input logic [NLINES-1:0] req_i,
  input logic [NLINES-1:0] mask_i,
  input logic [NLINES-1:0] insvc_i,
  input logic [W-1:0]      base_i,
  input logic              nested_i,
  input logic [NLINES-1:0] probe_i,
  input logic              irq_o,
  input logic [W-1:0]      line_o,
  input logic [W:0]        probe_prio_o,
  input logic [W-1:0]      probe_line_o
);
  logic              seen_q = 1'b0;
  logic [NLINES-1:0] cand_q, isr_q, probe_q;
  logic [W-1:0]      base_q;
  logic              nested_q;

  always_ff @(posedge clk) begin
    seen_q   <= !rst;
    cand_q   <= req_i & ~mask_i;
    isr_q    <= insvc_i;
    probe_q  <= probe_i;
    base_q   <= base_i;
    nested_q <= nested_i;
  end

  assert_grant_unmasked_R2: assert property (@(posedge clk) disable iff (rst)
    (seen_q && irq_o) |-> cand_q[line_o]);

  assert_top_in_service_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (seen_q && isr_q[base_q] && !(nested_q && (int'(base_q) == CASCADE_LINE))) |-> !irq_o);

  assert_idle_line_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (line_o == '0));

  assert_probe_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (seen_q && probe_q == '0) |-> (probe_prio_o == (W+1)'(NLINES) && probe_line_o == '0));

  assert_probe_found_R7: assert property (@(posedge clk) disable iff (rst)
    (seen_q && probe_q != '0) |-> (probe_prio_o < (W+1)'(NLINES) && probe_q[probe_line_o]));
endmodule

bind rot_prio_resolver rot_prio_resolver_checker #(
  .NLINES(NLINES), .CASCADE_LINE(CASCADE_LINE)
) u_checker (.*);

// File: tb/tb_rot_prio_resolver.sv
module tb_rot_prio_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 3;
  localparam int CASC = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0, mask_i = '0, insvc_i = '0, probe_i = '0;
  logic [W-1:0] base_i = '0;
  logic         nested_i = 1'b0;
  logic         irq_o;
  logic [W-1:0] line_o;
  logic [W:0]   probe_prio_o;
  logic [W-1:0] probe_line_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_prio_resolver dut (.*);

  function automatic int ref_search(logic [N-1:0] v, int b);
    for (int p = 0; p < N; p++) if (v[(p + b) % N]) return p;
    return N;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(logic [N-1:0] r, logic [N-1:0] m, logic [N-1:0] s,
                       int b, logic nst, logic [N-1:0] pr);
    @(negedge clk);
    req_i = r; mask_i = m; insvc_i = s; base_i = W'(b); nested_i = nst; probe_i = pr;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_grant(string req, logic g, int ln);
    check({req, " irq"}, int'(irq_o), int'(g));
    check({req, " line"}, int'(line_o), g ? ln : 0);
  endtask

  task automatic t_reset();
    req_i = 8'hFF; probe_i = 8'h10;
    @(posedge clk); #1;
    check("R1 irq", int'(irq_o), 0);
    check("R1 line", int'(line_o), 0);
    check("R1 probe_prio", int'(probe_prio_o), N);
    check("R1 probe_line", int'(probe_line_o), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_rotation();
    apply(8'b1010_0100, 0, 0, 0, 0, 0); expect_grant("R3 base0", 1, 2);
    apply(8'b0010_0010, 0, 0, 3, 0, 0); expect_grant("R3 base3", 1, 5);
    apply(8'b0000_0011, 0, 0, 1, 0, 0); expect_grant("R3 wrap", 1, 1);
    apply(8'b1000_0001, 0, 0, 0, 0, 0); expect_grant("R3 line0 top", 1, 0);
  endtask

  task automatic t_mask();
    apply(8'h06, 8'h02, 0, 0, 0, 0); expect_grant("R2 masked skip", 1, 2);
    apply(8'h10, 8'h10, 0, 0, 0, 0); expect_grant("R2 R5 all masked", 0, 0);
    apply(8'h00, 8'h00, 0, 5, 0, 0); expect_grant("R5 no request", 0, 0);
  endtask

  task automatic t_service();
    apply(8'h08, 0, 8'h08, 0, 0, 0); expect_grant("R4 equal", 0, 0);
    apply(8'h04, 0, 8'h08, 0, 0, 0); expect_grant("R4 higher", 1, 2);
    apply(8'h10, 0, 8'h08, 0, 0, 0); expect_grant("R4 R5 lower", 0, 0);
    apply(8'h01, 0, 8'h80, 7, 0, 0); expect_grant("R4 rotated", 0, 0);
  endtask

  task automatic t_nested();
    apply(8'h04, 0, 8'h04, 0, 1, 0); expect_grant("R6 nested on", 1, 2);
    apply(8'h04, 0, 8'h04, 0, 0, 0); expect_grant("R6 nested off", 0, 0);
    apply(8'h04, 0, 8'h06, 0, 1, 0); expect_grant("R6 other bit", 0, 0);
  endtask

  task automatic t_probe();
    apply(0, 0, 0, 0, 0, 8'h00);
    check("R7 empty prio", int'(probe_prio_o), N);
    check("R7 empty line", int'(probe_line_o), 0);
    apply(0, 0, 0, 6, 0, 8'h81);
    check("R7 prio", int'(probe_prio_o), 1);
    check("R7 line", int'(probe_line_o), 7);
  endtask

  task automatic t_latency();
    apply(8'h01, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_i = 8'h20;
    #1;
    expect_grant("R8 hold", 1, 0);
    @(posedge clk); #1;
    expect_grant("R8 update", 1, 5);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r, m, s, pr;
      int b, rp, sp, pp;
      logic nst;
      r = N'($urandom); m = N'($urandom & $urandom); s = N'($urandom & $urandom);
      pr = N'($urandom); b = i % N; nst = 1'($urandom);
      apply(r, m, s, b, nst, pr);
      rp = ref_search(r & ~m, b);
      sp = ref_search(nst ? (s & ~(N'(1) << CASC)) : s, b);
      pp = ref_search(pr, b);
      expect_grant("R3 R4 sweep", rp < sp, (rp + b) % N);
      check("R7 sweep prio", int'(probe_prio_o), pp);
      check("R7 sweep line", int'(probe_line_o), (pp == N) ? 0 : (pp + b) % N);
    end
  endtask

  initial begin
    t_reset();
    t_rotation();
    t_mask();
    t_service();
    t_nested();
    t_probe();
    t_latency();
    t_sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule